// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one 32-bit timer channel. Software loads a count and a reload constant, picks a count source and sets a start bit. The counter then steps down by one on each count enable from that source. When the counter is at zero, the next step loads it from the reload constant instead of wrapping. The same step sets a sticky underflow flag, and that flag can drive an interrupt line.

There are six usable count sources. Four are fixed divisions of the block clock, taken from a free-running divider. The fifth is a real-time-clock tick input. The sixth is an external pin, counted on its rising edges, its falling edges or both. The tick and pin inputs are asynchronous. They are resynchronised and edge-detected inside the block, and each detected edge gives a count enable that lasts one cycle.

Software reaches three registers through a single-cycle write port and a combinational read port.

| Address | Register |
|---|---|
| 0 | control/status |
| 1 | reload constant |
| 2 | counter |

The control/status fields are listed in R8.

Top module: `dntmr_channel`

## Requirements
- R1: Source codes 000, 001, 010 and 011 count once every 4, 16, 64 and 256 clock cycles. A window of k times that period gives exactly k steps, whatever the divider phase.
- R2: Source code 100 counts one step for each rising edge of `rtc_tick_i`. The input passes through a two-flop synchroniser first.
- R3: Source code 101 counts edges of `ext_clk_i` after a two-flop synchroniser. The edge field selects which edges count: 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both.
- R4: The reserved source codes 110 and 111 never change the counter, even with start set and both inputs toggling.
- R5: A step taken while the counter holds 0 loads the reload constant into the counter. After reset the reload constant and the counter both read 0xFFFFFFFF and the control register reads 0.
- R6: Each underflow sets the flag (control bit 8). Writing 0 to bit 8 clears the flag, and writing 1 leaves it unchanged. If an underflow and a clear fall in the same cycle, the flag ends set.
- R7: `irq_o` is 1 exactly when the flag and the interrupt enable (control bit 6) are both 1. The enable is 0 after reset.
- R8: The control fields are: bit 0 start, bits 3:1 source code, bits 5:4 edge field, bit 6 interrupt enable and bit 8 flag. The counter steps only while start is 1. A write to the counter takes effect and overrides a step in the same cycle.
- R9: Changing the source code does not alter the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider input |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick_i | input | 1 | Real-time-clock tick, asynchronous |
| ext_clk_i | input | 1 | External count pin, asynchronous |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Register address: 0 control, 1 reload constant, 2 counter |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Underflow interrupt request |

## Verification
Every cycle, the assertions check four things:
- a counter at zero that takes a step ends up holding the reload value;
- the flag stays set unless a zero is written to it;
- a stopped channel, or one set to a reserved source, holds its count;
- a counter write always lands.

Only the bench scenarios can show the following:
- the exact step counts for each divider, edge mode and the tick source;
- the same-cycle race between a flag clear and an underflow;
- the interrupt gating;
- that the reset values are correct.

// File: rtl/dntmr_pkg.sv
package dntmr_pkg;

    typedef enum logic [2:0] {
        SRC_DIV4   = 3'd0,
        SRC_DIV16  = 3'd1,
        SRC_DIV64  = 3'd2,
        SRC_DIV256 = 3'd3,
        SRC_RTC    = 3'd4,
        SRC_EXT    = 3'd5,
        SRC_RSV6   = 3'd6,
        SRC_RSV7   = 3'd7
    } src_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    localparam int CTL_START    = 0;
    localparam int CTL_SRC_LSB  = 1;
    localparam int CTL_EDGE_LSB = 4;
    localparam int CTL_IRQEN    = 6;
    localparam int CTL_FLAG     = 8;

endpackage

// File: rtl/dntmr_prescaler.sv
module dntmr_prescaler #(
    parameter int NUM_TAPS  = 4,
    parameter int STEP_LOG2 = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [NUM_TAPS-1:0] tap_o
);
    localparam int DIV_W = NUM_TAPS * STEP_LOG2;

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // Tap i pulses once every 2^((i+1)*STEP_LOG2) cycles
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_o[i] = &div_q[(i+1)*STEP_LOG2-1:0];
    end

    // R1: the fastest tap never pulses on two cycles in a row
    a_r1_tap_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o[0] |=> !tap_o[0]);

endmodule

// File: rtl/dntmr_edge_det.sv
module dntmr_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_i,
    input  logic [1:0] mode_i,   // 00 rise, 01 fall, 1x both
    output logic       pulse_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t s_d, s_q;
    logic rise, fall;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], sig_i};
        s_d.prev = s_q.sync[SYNC_STAGES-1];
        rise     = s_q.sync[SYNC_STAGES-1] & ~s_q.prev;
        fall     = ~s_q.sync[SYNC_STAGES-1] & s_q.prev;
        if (mode_i[1])      pulse_o = rise | fall;
        else if (mode_i[0]) pulse_o = fall;
        else                pulse_o = rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/dntmr_channel.sv
module dntmr_channel
    import dntmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick_i,
    input  logic             ext_clk_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             irq_o
);
    localparam int NUM_TAPS  = 4;
    localparam int STEP_LOG2 = 2;
    localparam int PAD_W     = CNT_W - CTL_FLAG - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        logic             start;
        src_e             src;
        logic [1:0]       edge_sel;
        logic             irq_en;
        logic             flag;
    } chan_st_t;

    chan_st_t s_d, s_q;

    logic [NUM_TAPS-1:0] taps;
    logic rtc_pulse, ext_pulse;
    logic ctrl_wr, reload_wr, cnt_wr;
    logic tick, step, underflow;

    dntmr_prescaler #(.NUM_TAPS(NUM_TAPS), .STEP_LOG2(STEP_LOG2)) u_presc (
        .clk(clk), .rst_n(rst_n), .tap_o(taps)
    );

    dntmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_rtc_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(rtc_tick_i), .mode_i(2'b00), .pulse_o(rtc_pulse)
    );

    dntmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_ext_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(ext_clk_i), .mode_i(s_q.edge_sel), .pulse_o(ext_pulse)
    );

    always_comb begin
        ctrl_wr   = reg_we_i && (reg_addr_i == ADDR_CTRL);
        reload_wr = reg_we_i && (reg_addr_i == ADDR_RELOAD);
        cnt_wr    = reg_we_i && (reg_addr_i == ADDR_COUNT);

        case (s_q.src)
            SRC_DIV4, SRC_DIV16, SRC_DIV64, SRC_DIV256: tick = taps[s_q.src[1:0]];
            SRC_RTC:                                    tick = rtc_pulse;
            SRC_EXT:                                    tick = ext_pulse;
            default:                                    tick = 1'b0;
        endcase

        step      = s_q.start && tick;
        underflow = step && !cnt_wr && (s_q.cnt == '0);

        s_d = s_q;
        if (cnt_wr)         s_d.cnt = reg_wdata_i;
        else if (underflow) s_d.cnt = s_q.reload;
        else if (step)      s_d.cnt = s_q.cnt - 1'b1;

        if (reload_wr) s_d.reload = reg_wdata_i;

        if (ctrl_wr) begin
            s_d.start    = reg_wdata_i[CTL_START];
            s_d.src      = src_e'(reg_wdata_i[CTL_SRC_LSB +: 3]);
            s_d.edge_sel = reg_wdata_i[CTL_EDGE_LSB +: 2];
            s_d.irq_en   = reg_wdata_i[CTL_IRQEN];
            if (!reg_wdata_i[CTL_FLAG]) s_d.flag = 1'b0;
        end
        if (underflow) s_d.flag = 1'b1;

        case (reg_addr_i)
            ADDR_CTRL:   reg_rdata_o = {{PAD_W{1'b0}}, s_q.flag, 1'b0, s_q.irq_en,
                                        s_q.edge_sel, s_q.src, s_q.start};
            ADDR_RELOAD: reg_rdata_o = s_q.reload;
            ADDR_COUNT:  reg_rdata_o = s_q.cnt;
            default:     reg_rdata_o = '0;
        endcase

        irq_o = s_q.flag && s_q.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.cnt      <= '1;
            s_q.reload   <= '1;
            s_q.src      <= SRC_DIV4;
        end else begin
            s_q <= s_d;
        end
    end

    // R5: a step at zero brings in the reload constant
    a_r5_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_wr && s_q.cnt == '0) |=> (s_q.cnt == $past(s_q.reload)));

    // R6: the flag only drops after a zero is written to it
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !(ctrl_wr && !reg_wdata_i[CTL_FLAG])) |=> s_q.flag);

    // R4: reserved source codes hold the count
    a_r4_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.src == SRC_RSV6 || s_q.src == SRC_RSV7) && !cnt_wr) |=> $stable(s_q.cnt));

    // R8: a stopped channel holds the count
    a_r8_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.start && !cnt_wr) |=> $stable(s_q.cnt));

    // R8: a counter write always lands
    a_r8_write_priority: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (s_q.cnt == $past(reg_wdata_i)));

endmodule

// File: tb/dntmr_channel_tb.sv
`timescale 1ns/1ps
module dntmr_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        ext_clk = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    dntmr_channel u_dut (
        .clk(clk), .rst_n(rst_n), .rtc_tick_i(rtc_tick), .ext_clk_i(ext_clk),
        .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic [2:0]  src;
        logic [1:0]  edg;
        logic [31:0] cnt0;
        logic [31:0] rld;
        logic [15:0] win;
        logic [7:0]  pulses;
        logic [31:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 32'd100, 32'd1000, 16'd40,   8'd0, 32'd90, 1'b0},  // R1 /4
        '{3'd1, 2'd0, 32'd100, 32'd1000, 16'd160,  8'd0, 32'd90, 1'b0},  // R1 /16
        '{3'd2, 2'd0, 32'd50,  32'd1000, 16'd640,  8'd0, 32'd40, 1'b0},  // R1 /64
        '{3'd3, 2'd0, 32'd20,  32'd1000, 16'd2560, 8'd0, 32'd10, 1'b0},  // R1 /256
        '{3'd0, 2'd0, 32'd2,   32'd5,    16'd16,   8'd0, 32'd4,  1'b1},  // R5 underflow
        '{3'd4, 2'd0, 32'd30,  32'd1000, 16'd8,    8'd7, 32'd23, 1'b0},  // R2 tick
        '{3'd5, 2'd0, 32'd30,  32'd1000, 16'd8,    8'd5, 32'd25, 1'b0},  // R3 rise
        '{3'd5, 2'd1, 32'd30,  32'd1000, 16'd8,    8'd5, 32'd25, 1'b0},  // R3 fall
        '{3'd5, 2'd2, 32'd30,  32'd1000, 16'd8,    8'd5, 32'd20, 1'b0},  // R3 both
        '{3'd5, 2'd3, 32'd30,  32'd1000, 16'd8,    8'd4, 32'd22, 1'b0},  // R3 both
        '{3'd6, 2'd2, 32'd30,  32'd1000, 16'd64,   8'd4, 32'd30, 1'b0},  // R4 110
        '{3'd7, 2'd2, 32'd30,  32'd1000, 16'd64,   8'd4, 32'd30, 1'b0},  // R4 111
        '{3'd5, 2'd0, 32'd1,   32'd9,    16'd8,    8'd3, 32'd8,  1'b1}   // R5 ext underflow
    };

    function automatic logic [31:0] mk_ctrl(input logic start, input logic [2:0] src,
                                            input logic [1:0] edg, input logic irqen,
                                            input logic flag);
        return {23'd0, flag, 1'b0, irqen, edg, src, start};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_inputs(input int n);
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            rtc_tick = 1'b1; ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            rtc_tick = 1'b0; ext_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(2'd0, r); check("R5 ctrl after reset", r, 32'h0);
        rd(2'd1, r); check("R5 reload after reset", r, 32'hFFFF_FFFF);
        rd(2'd2, r); check("R5 count after reset", r, 32'hFFFF_FFFF);
        check("R7 irq after reset", {31'd0, irq}, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            wr(2'd1, v.rld);
            wr(2'd2, v.cnt0);
            wr(2'd0, mk_ctrl(1'b0, v.src, v.edg, 1'b0, 1'b0));
            wr(2'd0, mk_ctrl(1'b1, v.src, v.edg, 1'b0, 1'b1));
            pulse_inputs(int'(v.pulses));
            repeat (int'(v.win) - 2) @(negedge clk);
            wr(2'd0, mk_ctrl(1'b0, v.src, v.edg, 1'b0, 1'b1));
            rd(2'd2, r);
            check($sformatf("R1/R2/R3/R4/R5 vector %0d count", i), r, v.exp_cnt);
            rd(2'd0, r);
            check($sformatf("R6 vector %0d flag", i), {31'd0, r[8]}, {31'd0, v.exp_flag});
        end

        // R6: clear written in the same cycle as an underflow
        wr(2'd0, mk_ctrl(1'b1, 3'd5, 2'd0, 1'b0, 1'b0));
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd7);
        repeat (4) @(negedge clk);
        ext_clk = 1'b1;
        @(negedge clk);
        wr(2'd0, mk_ctrl(1'b1, 3'd5, 2'd0, 1'b0, 1'b0));
        rd(2'd0, r); check("R6 underflow beats clear", {31'd0, r[8]}, 32'd1);
        rd(2'd2, r); check("R5 reload at race", r, 32'd7);
        ext_clk = 1'b0;
        wr(2'd0, mk_ctrl(1'b0, 3'd5, 2'd0, 1'b0, 1'b1));
        repeat (4) @(negedge clk);

        // R7 / R6: interrupt gating and flag writes
        check("R7 irq off with enable 0", {31'd0, irq}, 32'd0);
        wr(2'd0, mk_ctrl(1'b0, 3'd0, 2'd0, 1'b1, 1'b1));
        check("R7 irq on with flag and enable", {31'd0, irq}, 32'd1);
        rd(2'd0, r); check("R6 writing 1 keeps flag", {31'd0, r[8]}, 32'd1);
        wr(2'd0, mk_ctrl(1'b0, 3'd0, 2'd0, 1'b1, 1'b0));
        rd(2'd0, r); check("R6 writing 0 clears flag", {31'd0, r[8]}, 32'd0);
        check("R7 irq off after clear", {31'd0, irq}, 32'd0);

        // R8: counter writes override count steps
        wr(2'd0, mk_ctrl(1'b1, 3'd0, 2'd0, 1'b0, 1'b1));
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd77;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            #1;
            check($sformatf("R8 write priority cycle %0d", k), reg_rdata, 32'd77);
        end
        reg_we = 1'b0;
        wr(2'd0, mk_ctrl(1'b0, 3'd0, 2'd0, 1'b0, 1'b1));

        // R8: no counting while stopped
        wr(2'd2, 32'd55);
        repeat (40) @(negedge clk);
        rd(2'd2, r); check("R8 stopped holds", r, 32'd55);

        // R9: selection change keeps the counter
        wr(2'd2, 32'd123);
        wr(2'd0, mk_ctrl(1'b0, 3'd3, 2'd0, 1'b0, 1'b1));
        wr(2'd0, mk_ctrl(1'b0, 3'd1, 2'd0, 1'b0, 1'b1));
        rd(2'd2, r); check("R9 source change keeps count", r, 32'd123);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule